// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits at the head of a receive path and looks only at the destination address, which is the first six bytes of each incoming frame. It reads them from a byte stream as they arrive and gives a single verdict: keep the frame or drop it without complaint. The payload, the frame check sequence and storage are handled elsewhere. The block keeps no state between frames.

Three enable inputs, a 48-bit station address and a 64-bit multicast hash table control the verdict. The all-ones address is treated as broadcast. Any other address whose first byte has bit 0 set is a group (multicast) address and is matched through the hash table. All remaining addresses are unicast and are compared with the station address. Promiscuous mode overrides all of these checks. The hash bin comes from a CRC-32 that the block updates one byte per accepted cycle, so the verdict is ready one clock after the sixth address byte.

Top module: `mac_dest_filter`

## Requirements
- R1: When `promisc_en` is 1, every complete six-byte address gives `accept` = 1.
- R2: An address of six 0xFF bytes is broadcast. Without promiscuous mode it is accepted exactly when `bcast_en` is 1.
- R3: A non-broadcast address whose first received byte has bit 0 set is multicast. Without promiscuous mode it needs `mcast_en` = 1 and the addressed hash bit set; otherwise it is rejected.
- R4: The hash index is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7 and starts at all ones. Each byte is fed bit 0 first into a shift register that moves toward bit 31. There is no final inversion. The index selects `hash_tbl[index]`, which is bit (index mod 8) of table byte (index / 8), with table byte k at bits 8k+7:8k.
- R5: Without promiscuous mode, a unicast address is accepted only if all six bytes equal the station address. Received byte k is compared with `station_addr[8k+7:8k]`, and byte 0 arrives first.
- R6: `done` is high for exactly one cycle. That cycle follows the clock edge that takes the sixth address byte, and `accept` holds the verdict in that cycle. A rejected frame gives `done` with `accept` = 0 and no other signal.
- R7: `accept` keeps its value until the next start-of-frame byte. At that byte's edge it is cleared to 0.
- R8: A start-of-frame byte that arrives part-way through an address restarts the filter. The partial address produces no `done` and has no effect on the next verdict.
- R9: The filter ignores cycles with `byte_vld` = 0, bytes after the sixth, and bytes without a preceding start-of-frame. These produce no `done` and leave `accept` unchanged.
- R10: After reset, `done` and `accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| promisc_en | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept the broadcast address |
| mcast_en | input | 1 | Allow multicast matching through the hash table |
| station_addr | input | 48 | Own address; byte k in bits 8k+7:8k |
| hash_tbl | input | 64 | Multicast bins, bit n is bin n |
| byte_vld | input | 1 | A byte is present on `byte_dat` |
| byte_sof | input | 1 | With `byte_vld`, marks the first byte of a frame |
| byte_dat | input | 8 | Stream byte |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| accept | output | 1 | Verdict, held until the next start-of-frame |

## Verification
The assertions assume that the enables, station address and hash table stay constant while an address is being received. They also assume that `byte_sof` has meaning only together with `byte_vld`. The bench changes configuration only in the idle gap after `done`, and it raises `byte_sof` only on cycles where it also drives a byte. Within these limits it covers gaps between bytes, trailing bytes, orphan bytes and aborted addresses. The property checks therefore see only traffic the block is specified for.

// File: rtl/mdf_pkg.sv
// Shared constants and types for the destination address filter.
// Assumes the standard six-byte MAC address and a CRC-32 hash source.
package mdf_pkg;

    localparam int unsigned OCTET_W = 8;

    // Address class, fixed by the broadcast > multicast > unicast priority.
    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_kind_e;

endpackage

// File: rtl/mdf_seq.sv
// Byte sequencer: tracks the position within the destination address.
// Assumes byte_sof is meaningful only when byte_vld is high. A new
// start-of-frame always restarts at position 0.
module mdf_seq #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             byte_sof,
    output logic             take,
    output logic             first,
    output logic             last,
    output logic [CNT_W-1:0] idx
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode which incoming byte belongs to the address, and where it sits.
    always_comb begin
        first = byte_vld && byte_sof;
        take  = byte_vld && (byte_sof || busy_q);
        idx   = byte_sof ? '0 : cnt_q;
        last  = take && (idx == LAST_POS);
    end

    // Advance the position counter; stop after the final address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (first) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (take) begin
            busy_q <= (cnt_q != LAST_POS);
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // R9: the counter never runs past the address length
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));

    // R9: an idle sequencer only wakes on a start-of-frame byte
    p_wake_on_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !first) |=> !busy_q);

endmodule

// File: rtl/mdf_crc.sv
// Running CRC over the address bytes; exposes the hash bin of the
// CRC that includes the byte currently presented.
// Assumes one byte per take cycle, fed bit 0 first, preset to all ones.
module mdf_crc #(
    parameter int unsigned   CRC_W      = 32,
    parameter logic [31:0]   CRC_POLY   = 32'h04C1_1DB7,
    parameter int unsigned   HASH_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  first,
    input  logic [7:0]            dat,
    output logic [HASH_IDX_W-1:0] hash_idx
);

    localparam logic [CRC_W-1:0] POLY = CRC_W'(CRC_POLY);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    // Fold one byte, least significant bit first, into the shift register.
    always_comb begin
        crc_nxt = first ? '1 : crc_q;
        for (int b = 0; b < 8; b++) begin
            if (crc_nxt[CRC_W-1] ^ dat[b]) begin
                crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ POLY;
            end else begin
                crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
            end
        end
        hash_idx = crc_nxt[CRC_W-1 -: HASH_IDX_W];
    end

    // Keep the partial CRC between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (take) begin
            crc_q <= crc_nxt;
        end
    end

    // R9: bytes not belonging to an address leave the CRC untouched
    p_crc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/mdf_cmp.sv
// Address classifier: per-byte comparison against the station address,
// the all-ones broadcast check and the group bit of the first byte.
// Assumes the station address is stable while an address is received.
module mdf_cmp #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned CNT_W      = $clog2(ADDR_BYTES + 1),
    parameter int unsigned ADDR_W     = ADDR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [CNT_W-1:0]  idx,
    input  logic [7:0]        dat,
    input  logic [ADDR_W-1:0] station_addr,
    output logic              uni_hit,
    output logic              all_ones,
    output logic              group
);

    logic [7:0] sta_byte [ADDR_BYTES];
    logic [7:0] sta_sel;
    logic       hit_q;
    logic       ones_q;
    logic       grp_q;

    // Split the station address into bytes in receive order.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
        assign sta_byte[g] = station_addr[g*8 +: 8];
    end

    // Pick the station byte for this position and fold in the new byte.
    always_comb begin
        sta_sel = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == CNT_W'(k)) begin
                sta_sel = sta_byte[k];
            end
        end
        uni_hit  = (first ? 1'b1 : hit_q)  && (dat == sta_sel);
        all_ones = (first ? 1'b1 : ones_q) && (dat == 8'hFF);
        group    =  first ? dat[0] : grp_q;
    end

    // Carry the running flags between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            hit_q  <= uni_hit;
            ones_q <= all_ones;
            grp_q  <= group;
        end
    end

    // R3: the group bit is fixed by the first byte only
    p_group_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first) |=> $stable(grp_q));

    // R2: the broadcast flag can only survive an all-ones byte
    p_ones_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && all_ones) |-> (dat == 8'hFF));

endmodule

// File: rtl/mdf_decide.sv
// Verdict stage: classifies the address, applies the enables and the
// hash table, and registers done and accept.
// Assumes the enables and hash table are stable during an address.
module mdf_decide
    import mdf_pkg::*;
#(
    parameter int unsigned HASH_IDX_W = 6,
    parameter int unsigned HASH_W     = 1 << HASH_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  first,
    input  logic                  last,
    input  logic                  promisc_en,
    input  logic                  bcast_en,
    input  logic                  mcast_en,
    input  logic [HASH_W-1:0]     hash_tbl,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic                  uni_hit,
    input  logic                  all_ones,
    input  logic                  group,
    output logic                  done,
    output logic                  accept
);

    dst_kind_e kind;
    logic      verdict;

    // Rank the address class, then apply the matching rule.
    always_comb begin
        if (all_ones) begin
            kind = DST_BROADCAST;
        end else if (group) begin
            kind = DST_MULTICAST;
        end else begin
            kind = DST_UNICAST;
        end
        unique case (kind)
            DST_BROADCAST: verdict = bcast_en;
            DST_MULTICAST: verdict = mcast_en && hash_tbl[hash_idx];
            default:       verdict = uni_hit;
        endcase
        if (promisc_en) begin
            verdict = 1'b1;
        end
    end

    // Register the verdict at the last byte and clear it on a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                accept <= verdict;
            end else if (first) begin
                accept <= 1'b0;
            end
        end
    end

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: accept holds between frames
    p_accept_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!first && !last) |=> $stable(accept));

    // R7: a start-of-frame byte clears the previous verdict
    p_sof_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !last) |=> !accept);

    // R1: promiscuous mode always accepts
    p_promisc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (last && promisc_en) |=> (accept && done));

    // R2: broadcast is dropped when its enable is off
    p_bcast_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && all_ones && !promisc_en && !bcast_en) |=> !accept);

    // R3: multicast is dropped when its enable is off
    p_mcast_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && group && !all_ones && !promisc_en && !mcast_en) |=> !accept);

endmodule

// File: rtl/mac_dest_filter.sv
// Top of the destination address filter. Wires the sequencer, CRC hash,
// address classifier and verdict stage together.
// Assumes a byte stream with byte_sof qualified by byte_vld, and
// configuration held constant while an address is being received.
module mac_dest_filter #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_IDX_W = 6,
    parameter int unsigned CRC_W      = 32,
    parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
    parameter int unsigned ADDR_W     = ADDR_BYTES * 8,
    parameter int unsigned HASH_W     = 1 << HASH_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              promisc_en,
    input  logic              bcast_en,
    input  logic              mcast_en,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [HASH_W-1:0] hash_tbl,
    input  logic              byte_vld,
    input  logic              byte_sof,
    input  logic [7:0]        byte_dat,
    output logic              done,
    output logic              accept
);

    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

    logic                  take;
    logic                  first;
    logic                  last;
    logic [CNT_W-1:0]      idx;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  uni_hit;
    logic                  all_ones;
    logic                  group;

    mdf_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_W      (CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_sof (byte_sof),
        .take     (take),
        .first    (first),
        .last     (last),
        .idx      (idx)
    );

    mdf_crc #(
        .CRC_W      (CRC_W),
        .CRC_POLY   (CRC_POLY),
        .HASH_IDX_W (HASH_IDX_W)
    ) i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .dat      (byte_dat),
        .hash_idx (hash_idx)
    );

    mdf_cmp #(
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W)
    ) i_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .first        (first),
        .idx          (idx),
        .dat          (byte_dat),
        .station_addr (station_addr),
        .uni_hit      (uni_hit),
        .all_ones     (all_ones),
        .group        (group)
    );

    mdf_decide #(
        .HASH_IDX_W (HASH_IDX_W),
        .HASH_W     (HASH_W)
    ) i_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .first      (first),
        .last       (last),
        .promisc_en (promisc_en),
        .bcast_en   (bcast_en),
        .mcast_en   (mcast_en),
        .hash_tbl   (hash_tbl),
        .hash_idx   (hash_idx),
        .uni_hit    (uni_hit),
        .all_ones   (all_ones),
        .group      (group),
        .done       (done),
        .accept     (accept)
    );

endmodule

// File: tb/test_mac_dest_filter.sv
// Scoreboard bench: the driver queues the expected verdict of every
// complete address, and the monitor compares it when done fires.
module test_mac_dest_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        promisc_en = 1'b0;
    logic        bcast_en = 1'b0;
    logic        mcast_en = 1'b0;
    logic [47:0] station_addr = 48'h6655_4433_2210;
    logic [63:0] hash_tbl = '0;
    logic        byte_vld = 1'b0;
    logic        byte_sof = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic        done;
    logic        accept;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic   exp_q[$];
    string  tag_q[$];
    logic   prev_done = 1'b0;
    logic   last_exp = 1'b0;

    always #10 clk = ~clk;

    mac_dest_filter i_mac_dest_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .promisc_en   (promisc_en),
        .bcast_en     (bcast_en),
        .mcast_en     (mcast_en),
        .station_addr (station_addr),
        .hash_tbl     (hash_tbl),
        .byte_vld     (byte_vld),
        .byte_sof     (byte_sof),
        .byte_dat     (byte_dat),
        .done         (done),
        .accept       (accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // R4 model: bit-serial CRC, address bit n is byte n/8 bit n%8.
    function automatic logic [31:0] model_crc(input logic [47:0] d);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            if (c[31] != d[n]) c = (c << 1) ^ 32'h04C1_1DB7;
            else               c = c << 1;
        end
        return c;
    endfunction

    function automatic logic model_accept(input logic [47:0] d);
        logic [31:0] c;
        c = model_crc(d);
        if (promisc_en)              return 1'b1;
        if (d == 48'hFFFF_FFFF_FFFF) return bcast_en;
        if (d[0])                    return mcast_en && hash_tbl[c[31:26]];
        return d == station_addr;
    endfunction

    function automatic string tag_of(input logic [47:0] d);
        if (promisc_en)              return "R1";
        if (d == 48'hFFFF_FFFF_FFFF) return "R2";
        if (d[0])                    return "R3/R4";
        return "R5";
    endfunction

    // Driver: one complete address with optional gaps and trailing bytes.
    task automatic send_frame(input logic [47:0] d, input int gap, input int extra);
        last_exp = model_accept(d);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag_of(d));
        @(negedge clk);
        byte_vld = 1'b1; byte_sof = 1'b1; byte_dat = d[7:0];
        @(negedge clk);
        byte_vld = 1'b0; byte_sof = 1'b0;
        check("R7 clear at sof", accept, 1'b0);
        for (int k = 1; k < 6; k++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            byte_vld = 1'b1; byte_dat = d[k*8 +: 8];
            @(negedge clk);
            byte_vld = 1'b0;
        end
        for (int e = 0; e < extra; e++) begin
            byte_vld = 1'b1; byte_dat = 8'($urandom);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R7/R9 hold", accept, last_exp);
    endtask

    // Driver: an aborted address of n bytes (R8).
    task automatic send_partial(input logic [47:0] d, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_sof = (k == 0); byte_dat = d[k*8 +: 8];
        end
    endtask

    // Monitor: compare each done against the queued verdict.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) begin
                checks++; errors++;
                $display("FAIL R6 done width: actual 2+ cycles expected 1");
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8/R9 unexpected done: actual 1 expected 0");
                end else begin
                    check({tag_q.pop_front(), " verdict"}, accept, exp_q.pop_front());
                end
            end
        end
        prev_done = done;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] mc;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        check("R10 reset done", done, 1'b0);
        check("R10 reset accept", accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 unicast
        send_frame(station_addr, 0, 0);
        send_frame(station_addr ^ 48'h0100_0000_0000, 0, 0);
        send_frame(station_addr ^ 48'h0000_0000_0002, 1, 0);
        send_frame(station_addr, 2, 3);

        // R2 broadcast
        send_frame('1, 0, 0);
        bcast_en = 1'b1;
        send_frame('1, 0, 0);
        send_frame(station_addr, 0, 0);

        // R3 / R4 multicast
        mc = 48'h0100_5E00_0001;
        c = model_crc(mc);
        hash_tbl = 64'h0;
        hash_tbl[c[31:26]] = 1'b1;
        send_frame(mc, 0, 0);
        mcast_en = 1'b1;
        send_frame(mc, 0, 0);
        hash_tbl = ~hash_tbl;
        send_frame(mc, 1, 0);
        mc = 48'hAB89_6745_2303;
        hash_tbl = 64'h0;
        c = model_crc(mc);
        hash_tbl[c[31:26]] = 1'b1;
        send_frame(mc, 0, 2);
        bcast_en = 1'b0;
        send_frame('1, 0, 0);

        // R1 promiscuous
        promisc_en = 1'b1;
        send_frame(48'h1234_5678_9ABC, 0, 0);
        send_frame('1, 0, 0);
        send_frame(48'h0000_0000_0011, 0, 0);
        promisc_en = 1'b0; mcast_en = 1'b0;

        // R8 restart mid-frame
        send_partial(station_addr, 3);
        send_frame(station_addr ^ 48'h0080_0000_0000, 0, 0);
        send_partial(48'h9999_9999_9998, 5);
        send_frame(station_addr, 0, 0);

        // R9 orphan bytes without start-of-frame
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_sof = 1'b0; byte_dat = 8'h5A;
        end
        @(negedge clk);
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 orphan bytes", accept, last_exp);

        // Mixed random traffic
        for (int t = 0; t < 60; t++) begin
            logic [47:0] d;
            promisc_en = ($urandom % 5) == 0;
            bcast_en = 1'($urandom);
            mcast_en = 1'($urandom);
            hash_tbl = {$urandom, $urandom};
            case ($urandom % 4)
                0: d = station_addr;
                1: d = '1;
                2: d = {$urandom, 16'($urandom)} | 48'h1;
                default: d = {$urandom, 16'($urandom)} & ~48'h1;
            endcase
            send_frame(d, int'($urandom % 3), int'($urandom % 3));
        end

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing done: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule